// File: doc/BRIEF.md
# Flash Status-Register Write-Protection Controller

This block keeps the protection state of a serial flash device and rules on every write-type command the command decoder hands it. It holds a write-enable latch, a status-lock bit and a two-bit protect-zone field. On each decoded strobe it answers accept or reject in the same cycle. The state change caused by an accepted command is visible in the status byte one clock later.

Whether the status register may be rewritten depends on three things together: the lock bit, the active-low write-protect pin and the write-enable latch. When the lock bit is set and the pin is low, the device is in a hardware-locked mode. That mode can be entered in either order, and the only way out is to raise the pin. Program and sector-erase requests are compared against the zone selected by the protect field. Chip erase is refused while any zone is protected.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the lock bit, the protect field and the write-enable latch are all 0. The status byte then reads 0x00, apart from bit 0, which carries `busy`.
- R2: `cmd_wren` and `cmd_wrdi` are always accepted. `cmd_wren` sets the write-enable latch (status bit 1) on the next cycle, and `cmd_wrdi` clears it.
- R3: While the lock bit is 0, a status write is accepted only when the write-enable latch is 1, whatever the level of `wp_n`.
- R4: While the lock bit is 1 and `wp_n` is 1, a status write is accepted only when the write-enable latch is 1.
- R5: While the lock bit is 1 and `wp_n` is 0, every status write is rejected and leaves the status byte unchanged. This mode is reached in either order of setting the bit and lowering the pin, and it ends when `wp_n` rises.
- R6: An accepted status write loads the lock bit (status bit 7) from data bit 7 and the protect field (status bits 3:2) from data bits 3:2. It ignores the other data bits and clears the write-enable latch. Status bits 6:4 always read 0.
- R7: Page program, sector erase and chip erase are rejected whenever the write-enable latch is 0.
- R8: With the latch set, a page program or sector erase is rejected if its address lies in the protected zone, and accepted otherwise. The protect-field codes are: 00 protects nothing, 01 protects the upper quarter (the two top address bits are 11), 10 protects the upper half (the top address bit is 1), 11 protects every address. An accepted program or erase clears the latch.
- R9: With the latch set, chip erase is accepted only when the protect field is 00. When accepted, it clears the latch.
- R10: Status bit 0 follows `busy` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Chip-erase strobe |
| addr | input | ADDR_W | Target address of program or erase |
| sr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Busy flag reported in status bit 0 |
| cmd_accept | output | 1 | Command accepted (same cycle as strobe) |
| cmd_reject | output | 1 | Command rejected (same cycle as strobe) |
| status | output | 8 | Current status byte |

## Verification
The accept and reject outputs are combinational, so they are due in the same cycle as the strobe. The bench samples them 2 ns after driving inputs at the falling edge. The state update passes through one register, so the status byte is due after the next rising edge. The bench samples it 6 ns after that edge, before the next stimulus. Status bit 0 is combinational from `busy` and is checked in the same window. A bench model advances only at the rising edge that the design uses. Strobes are one-hot per cycle.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
    localparam int SR_W       = 8;
    localparam int BIT_LOCK   = 7;
    localparam int BIT_ZONE_H = 3;
    localparam int BIT_ZONE_L = 2;
    localparam int BIT_WEL    = 1;
    localparam int BIT_BUSY   = 0;

    typedef struct packed {
        logic       lock;
        logic [1:0] zone;
        logic       wel;
    } wp_state_t;

    typedef struct packed {
        logic       set_wel;
        logic       clr_wel;
        logic       load_sr;
    } wp_ctl_t;
endpackage

// File: rtl/wp_zone_decode.sv
module wp_zone_decode #(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        zone,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_zone,
    output logic              any_zone
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;
    assign top2 = addr[TOP -: 2];

    always_comb begin
        case (zone)
            2'b00:   in_zone = 1'b0;
            2'b01:   in_zone = (top2 == 2'b11);
            2'b10:   in_zone = top2[1];
            default: in_zone = 1'b1;
        endcase
    end

    assign any_zone = |zone;
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
    import flash_wp_pkg::*;
(
    input  wp_state_t st,
    input  logic      cmd_wren,
    input  logic      cmd_wrdi,
    input  logic      cmd_wrsr,
    input  logic      cmd_pp,
    input  logic      cmd_se,
    input  logic      cmd_be,
    input  logic      wp_n,
    input  logic      in_zone,
    input  logic      any_zone,
    output logic      cmd_accept,
    output logic      cmd_reject,
    output wp_ctl_t   ctl
);
    logic hw_locked;
    logic sr_ok;
    logic pe_ok;
    logic be_ok;

    assign hw_locked = st.lock & ~wp_n;
    assign sr_ok     = st.wel & ~hw_locked;
    assign pe_ok     = st.wel & ~in_zone;
    assign be_ok     = st.wel & ~any_zone;

    always_comb begin
        cmd_accept  = 1'b0;
        cmd_reject  = 1'b0;
        ctl         = '0;
        if (cmd_wren) begin
            cmd_accept  = 1'b1;
            ctl.set_wel = 1'b1;
        end else if (cmd_wrdi) begin
            cmd_accept  = 1'b1;
            ctl.clr_wel = 1'b1;
        end else if (cmd_wrsr) begin
            cmd_accept  = sr_ok;
            cmd_reject  = ~sr_ok;
            ctl.load_sr = sr_ok;
            ctl.clr_wel = sr_ok;
        end else if (cmd_pp | cmd_se) begin
            cmd_accept  = pe_ok;
            cmd_reject  = ~pe_ok;
            ctl.clr_wel = pe_ok;
        end else if (cmd_be) begin
            cmd_accept  = be_ok;
            cmd_reject  = ~be_ok;
            ctl.clr_wel = be_ok;
        end
    end
endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg
    import flash_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  wp_ctl_t         ctl,
    input  logic [SR_W-1:0] sr_data,
    output wp_state_t       st_q
);
    wp_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (ctl.load_sr) begin
            st_d.lock = sr_data[BIT_LOCK];
            st_d.zone = sr_data[BIT_ZONE_H:BIT_ZONE_L];
        end
        if (ctl.set_wel)      st_d.wel = 1'b1;
        else if (ctl.clr_wel) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        sr_data,
    input  logic              wp_n,
    input  logic              busy,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic [7:0]        status
);
    wp_state_t st_q;
    wp_ctl_t   ctl;
    logic      in_zone;
    logic      any_zone;

    wp_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
        .zone     (st_q.zone),
        .addr     (addr),
        .in_zone  (in_zone),
        .any_zone (any_zone)
    );

    wp_cmd_gate u_gate (
        .st         (st_q),
        .cmd_wren   (cmd_wren),
        .cmd_wrdi   (cmd_wrdi),
        .cmd_wrsr   (cmd_wrsr),
        .cmd_pp     (cmd_pp),
        .cmd_se     (cmd_se),
        .cmd_be     (cmd_be),
        .wp_n       (wp_n),
        .in_zone    (in_zone),
        .any_zone   (any_zone),
        .cmd_accept (cmd_accept),
        .cmd_reject (cmd_reject),
        .ctl        (ctl)
    );

    wp_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .sr_data (sr_data),
        .st_q    (st_q)
    );

    always_comb begin
        status                          = '0;
        status[BIT_LOCK]                = st_q.lock;
        status[BIT_ZONE_H:BIT_ZONE_L]   = st_q.zone;
        status[BIT_WEL]                 = st_q.wel;
        status[BIT_BUSY]                = busy;
    end
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_se,
    input logic       cmd_be,
    input logic       wp_n,
    input logic       busy,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic [7:0] status
);
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wren |=> status[1]);

    a_r5_hw_lock_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && status[7] && !wp_n) |-> cmd_reject);

    a_r5_hw_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n) |=> $stable(status[7:2]));

    a_r7_no_wel_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_pp || cmd_se || cmd_be) && !status[1]) |-> cmd_reject);

    a_r9_chip_erase_zone: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_be && status[3:2] != 2'b00) |-> cmd_reject);

    a_r6_accept_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && (cmd_wrsr || cmd_pp || cmd_se || cmd_be)) |=> !status[1]);

    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);

    a_r10_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == busy);

    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wren   (cmd_wren),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_pp     (cmd_pp),
    .cmd_se     (cmd_se),
    .cmd_be     (cmd_be),
    .wp_n       (wp_n),
    .busy       (busy),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .status     (status)
);

// File: tb/flash_wp_ctrl_test.sv
`timescale 1ns/1ps
module flash_wp_ctrl_test;
    localparam int AW = 18;
    localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PP = 3, C_SE = 4, C_BE = 5, C_NONE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] sr_data = '0;
    logic wp_n = 1'b1, busy = 1'b0;
    logic cmd_accept, cmd_reject;
    logic [7:0] status;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic       m_lock = 0;
    logic [1:0] m_zone = 0;
    logic       m_wel = 0;

    always #10 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
        .addr(addr), .sr_data(sr_data), .wp_n(wp_n), .busy(busy),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic bz);
        return {m_lock, 3'b000, m_zone, m_wel, bz};
    endfunction

    function automatic logic zone_hit(input logic [1:0] z, input logic [AW-1:0] a);
        case (z)
            2'b00:   return 1'b0;
            2'b01:   return a[AW-1] & a[AW-2];
            2'b10:   return a[AW-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic exp_ok(input int c, input logic [AW-1:0] a, input logic wp);
        case (c)
            C_WREN, C_WRDI: return 1'b1;
            C_WRSR:         return m_wel & ~(m_lock & ~wp);
            C_PP, C_SE:     return m_wel & ~zone_hit(m_zone, a);
            C_BE:           return m_wel & (m_zone == 2'b00);
            default:        return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input int c, input logic wp);
        if (c == C_WREN || c == C_WRDI) return "R2";
        if (c == C_WRSR) return !m_wel ? "R3" : (m_lock ? (wp ? "R4" : "R5") : "R3");
        if (!m_wel) return "R7";
        if (c == C_BE) return "R9";
        return "R8";
    endfunction

    task automatic apply(input int c, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic wp, input logic bz);
        logic ok;
        string tg;
        @(negedge clk);
        cmd_wren = (c == C_WREN); cmd_wrdi = (c == C_WRDI); cmd_wrsr = (c == C_WRSR);
        cmd_pp = (c == C_PP); cmd_se = (c == C_SE); cmd_be = (c == C_BE);
        addr = a; sr_data = d; wp_n = wp; busy = bz;
        #2;
        ok = exp_ok(c, a, wp);
        tg = tag_of(c, wp);
        if (c != C_NONE)
            check(tg, {6'b0, cmd_accept, cmd_reject}, {6'b0, ok, ~ok});
        @(posedge clk);
        #1;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0; cmd_se = 0; cmd_be = 0;
        case (c)
            C_WREN: m_wel = 1'b1;
            C_WRDI: m_wel = 1'b0;
            C_WRSR: if (ok) begin m_lock = d[7]; m_zone = d[3:2]; m_wel = 1'b0; end
            C_PP, C_SE, C_BE: if (ok) m_wel = 1'b0;
            default: ;
        endcase
        #5;
        check(c == C_WRSR ? "R6" : "R10", status, exp_status(bz));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        #15;
        check("R1", status, 8'h00);
        busy = 1'b1; #1;
        check("R1", status, 8'h01);
        busy = 1'b0;
        rst_n = 1'b1;

        // R7: no latch, everything rejected
        apply(C_PP, 18'h00010, 8'h00, 1, 0);
        apply(C_BE, 18'h00000, 8'h00, 1, 0);
        apply(C_WRSR, 18'h0, 8'h8C, 0, 0);               // R3 rejected, no latch
        // R2
        apply(C_WREN, 18'h0, 8'h00, 1, 1);
        apply(C_WRDI, 18'h0, 8'h00, 1, 0);
        // R3 with pin low, lock 0 -> accepted; sets lock, zone 01, junk bits ignored (R6)
        apply(C_WREN, 18'h0, 8'h00, 0, 0);
        apply(C_WRSR, 18'h0, 8'hF7, 0, 0);               // lock=1 zone=01
        // now hardware locked (R5), order: bit set while pin low
        apply(C_WREN, 18'h0, 8'h00, 0, 0);
        apply(C_WRSR, 18'h0, 8'h00, 0, 0);               // rejected
        // R8 upper-quarter boundary
        apply(C_PP, 18'h2FFFF, 8'h00, 0, 0);            // below quarter -> accepted
        apply(C_WREN, 18'h0, 8'h00, 0, 0);
        apply(C_SE, 18'h30000, 8'h00, 0, 0);            // in quarter -> rejected
        apply(C_BE, 18'h0, 8'h00, 0, 0);                // R9 rejected, zone nonzero
        // exit by raising pin (R4)
        apply(C_WRSR, 18'h0, 8'h88, 1, 0);              // lock=1 zone=10
        apply(C_WREN, 18'h0, 8'h00, 1, 0);
        apply(C_PP, 18'h20000, 8'h00, 1, 0);            // upper half -> rejected
        apply(C_PP, 18'h1FFFF, 8'h00, 1, 0);            // lower half -> accepted
        // other order: bit set, then pin lowered
        apply(C_WREN, 18'h0, 8'h00, 1, 0);
        apply(C_NONE, 18'h0, 8'h00, 0, 0);
        apply(C_WRSR, 18'h0, 8'h00, 0, 0);              // R5 rejected
        apply(C_WRSR, 18'h0, 8'h00, 1, 0);              // R4 accepted, all clear
        apply(C_WREN, 18'h0, 8'h00, 1, 0);
        apply(C_BE, 18'h0, 8'h00, 1, 0);                // R9 accepted
        apply(C_WREN, 18'h0, 8'h00, 1, 0);
        apply(C_WRSR, 18'h0, 8'h0C, 1, 0);              // zone 11
        apply(C_WREN, 18'h0, 8'h00, 1, 0);
        apply(C_PP, 18'h00000, 8'h00, 1, 0);            // whole array -> rejected

        for (int i = 0; i < 600; i++) begin
            int c;
            logic [AW-1:0] a;
            c = $urandom_range(0, 6);
            if ($urandom_range(0, 3) == 0) c = C_WREN;
            a = AW'($urandom);
            apply(c, a, 8'($urandom), ($urandom_range(0, 2) != 0), 1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule